// File: doc/BRIEF.md
# Clock-Tracking PI Loop Filter

This block is the digital controller of a clock recovery loop that tracks an external reference. Once per measurement period the surrounding logic hands it two 16-bit snapshots of a free-running counter clocked by the recovered master clock: the current snapshot and the one from the previous period. The block compares the elapsed count with the count expected for the selected nominal rate. It turns the difference into a frequency error and integrates that into a phase error. A shift-only PI controller and a first-order smoothing stage then produce a 20-bit tuning word for a downstream oscillator modulator.

After every restart the first measurement does not feed the loop. Instead it performs a one-time coarse correction of the base tuning value, scaled by a per-rate gain, so the loop starts close to lock. A new tuning word is strobed out only when the smoothed correction actually moves. Between strobes the last word stays on the output.

Top module: `clkpi_loop_filter`

## Requirements
- R1: After reset, `tune_valid` is 0 and `tune_word` is 0. The low rate is selected, and the next measurement is handled as a fast-lock step.
- R2: The count error is (`snap_now` − `snap_prev` − expected) modulo 2^16, read as a signed 16-bit value. The expected count is 29184 when the latched rate is low (`rate_sel`=0) and 49152 when it is high (`rate_sel`=1). Both snapshots may wrap past 0xFFFF.
- R3: The first accepted measurement after reset or restart subtracts (count error × gain) from the base value and feeds a count error of zero to the loop. This measurement never raises `tune_valid`.
- R4: Each later accepted measurement adds the negated count error to the phase accumulator, then adds the new phase to the integral accumulator. The controller output is (phase shifted left 5) + (integral arithmetically shifted right 2), in 32-bit wraparound arithmetic.
- R5: The smoothed value y is updated as y + ((controller output − y) arithmetically shifted right 3).
- R6: `tune_valid` pulses for one cycle, in the cycle after `meas_valid`, and only when the new y differs from the previous y. Otherwise `tune_word` holds its last value.
- R7: The issued word is base + y, clamped to the range 0 to 0xFFFFF.
- R8: `restart` clears the phase, the integral and y, and re-arms fast lock. It also latches `rate_sel` and reloads the base value. A `meas_valid` in the same cycle as `restart` is ignored.
- R9: The base value is 498283 for the low rate and 478151 for the high rate. The fast-lock gain is 627 for both rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Clear loop state, latch rate, re-arm fast lock |
| rate_sel | input | 1 | Nominal rate picked at restart (0 low, 1 high) |
| meas_valid | input | 1 | One measurement per high cycle |
| snap_now | input | 16 | Counter snapshot at this period end |
| snap_prev | input | 16 | Counter snapshot at previous period end |
| tune_valid | output | 1 | One-cycle strobe for a new tuning word |
| tune_word | output | 20 | Clamped tuning word for the oscillator modulator |

## Verification
The clamp limits are the hardest states to reach from the ports. The smoothed correction grows by only a few counts per period, so ordinary drift would need an extremely long run to push base + y past either end. The stimulus uses the fast-lock step instead. It feeds a count error of −32768 or +32767 as the first measurement after a restart, which throws the base value far above 0xFFFFF or below zero in one period, and the next small error then produces a word that has to clamp. Snapshot pairs straddle the 16-bit wrap, and one restart coincides with a measurement to show that measurement is dropped.

// File: rtl/clkpi_pkg.sv
package clkpi_pkg;
    localparam int CNT_W  = 16;
    localparam int TUNE_W = 20;
    localparam int ACC_W  = 32;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t              base;
        acc_t              phase;
        acc_t              integ;
        acc_t              y;
        logic              fast;
        logic              rate;
        logic              tv;
        logic [TUNE_W-1:0] tw;
    } state_t;
endpackage

// File: rtl/clkpi_err_calc.sv
module clkpi_err_calc
    import clkpi_pkg::*;
#(
    parameter int EXP_LO = 29184,
    parameter int EXP_HI = 49152
) (
    input  logic [CNT_W-1:0] snap_now,
    input  logic [CNT_W-1:0] snap_prev,
    input  logic             rate,
    output acc_t             cnt_err
);
    localparam logic [CNT_W-1:0] EXP_LO_W = CNT_W'(EXP_LO);
    localparam logic [CNT_W-1:0] EXP_HI_W = CNT_W'(EXP_HI);
    localparam int               EXT_W    = ACC_W - CNT_W;

    logic [CNT_W-1:0] exp_cnt;
    logic [CNT_W-1:0] raw;

    always_comb begin
        exp_cnt = rate ? EXP_HI_W : EXP_LO_W;
        raw     = snap_now - snap_prev - exp_cnt;
        cnt_err = {{EXT_W{raw[CNT_W-1]}}, raw};
    end
endmodule

// File: rtl/clkpi_pi_core.sv
module clkpi_pi_core
    import clkpi_pkg::*;
#(
    parameter int KP_SH  = 5,
    parameter int KI_SH  = 2,
    parameter int IIR_SH = 3
) (
    input  acc_t err_in,
    input  acc_t phase_q,
    input  acc_t integ_q,
    input  acc_t y_q,
    output acc_t phase_n,
    output acc_t integ_n,
    output acc_t y_n
);
    acc_t freq_err;
    acc_t ctrl_x;
    acc_t delta;

    always_comb begin
        freq_err = -err_in;
        phase_n  = phase_q + freq_err;
        integ_n  = integ_q + phase_n;
        ctrl_x   = (phase_n <<< KP_SH) + (integ_n >>> KI_SH);
        delta    = ctrl_x - y_q;
        y_n      = y_q + (delta >>> IIR_SH);
    end
endmodule

// File: rtl/clkpi_out_clamp.sv
module clkpi_out_clamp
    import clkpi_pkg::*;
(
    input  acc_t              base,
    input  acc_t              y,
    output logic [TUNE_W-1:0] word
);
    localparam acc_t TOP_V = acc_t'((64'd1 << TUNE_W) - 64'd1);

    acc_t sum;
    acc_t lim;

    always_comb begin
        sum = base + y;
        if (sum < 0)
            lim = '0;
        else if (sum > TOP_V)
            lim = TOP_V;
        else
            lim = sum;
        word = TUNE_W'(lim);
    end
endmodule

// File: rtl/clkpi_loop_filter.sv
module clkpi_loop_filter
    import clkpi_pkg::*;
#(
    parameter int EXP_LO  = 29184,
    parameter int EXP_HI  = 49152,
    parameter int BASE_LO = 498283,
    parameter int BASE_HI = 478151,
    parameter int GAIN_LO = 627,
    parameter int GAIN_HI = 627,
    parameter int KP_SH   = 5,
    parameter int KI_SH   = 2,
    parameter int IIR_SH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              rate_sel,
    input  logic              meas_valid,
    input  logic [CNT_W-1:0]  snap_now,
    input  logic [CNT_W-1:0]  snap_prev,
    output logic              tune_valid,
    output logic [TUNE_W-1:0] tune_word
);
    localparam acc_t BASE_LO_A = acc_t'(BASE_LO);
    localparam acc_t BASE_HI_A = acc_t'(BASE_HI);
    localparam acc_t GAIN_LO_A = acc_t'(GAIN_LO);
    localparam acc_t GAIN_HI_A = acc_t'(GAIN_HI);

    state_t st_d, st_q;

    acc_t              err_raw;
    acc_t              err_eff;
    acc_t              base_eff;
    acc_t              gain_cur;
    acc_t              phase_n, integ_n, y_n;
    logic [TUNE_W-1:0] word_n;
    logic              take;

    clkpi_err_calc #(
        .EXP_LO (EXP_LO),
        .EXP_HI (EXP_HI)
    ) u_err (
        .snap_now  (snap_now),
        .snap_prev (snap_prev),
        .rate      (st_q.rate),
        .cnt_err   (err_raw)
    );

    // fast lock: seed the base from the first error, hide that error
    always_comb begin
        gain_cur = st_q.rate ? GAIN_HI_A : GAIN_LO_A;
        if (st_q.fast) begin
            err_eff  = '0;
            base_eff = st_q.base - err_raw * gain_cur;
        end else begin
            err_eff  = err_raw;
            base_eff = st_q.base;
        end
    end

    clkpi_pi_core #(
        .KP_SH  (KP_SH),
        .KI_SH  (KI_SH),
        .IIR_SH (IIR_SH)
    ) u_core (
        .err_in  (err_eff),
        .phase_q (st_q.phase),
        .integ_q (st_q.integ),
        .y_q     (st_q.y),
        .phase_n (phase_n),
        .integ_n (integ_n),
        .y_n     (y_n)
    );

    clkpi_out_clamp u_clamp (
        .base (base_eff),
        .y    (y_n),
        .word (word_n)
    );

    assign take = meas_valid && !restart;

    always_comb begin
        st_d    = st_q;
        st_d.tv = 1'b0;
        if (restart) begin
            st_d.rate  = rate_sel;
            st_d.base  = rate_sel ? BASE_HI_A : BASE_LO_A;
            st_d.phase = '0;
            st_d.integ = '0;
            st_d.y     = '0;
            st_d.fast  = 1'b1;
        end else if (meas_valid) begin
            st_d.base  = base_eff;
            st_d.fast  = 1'b0;
            st_d.phase = phase_n;
            st_d.integ = integ_n;
            st_d.y     = y_n;
            if (y_n != st_q.y) begin
                st_d.tv = 1'b1;
                st_d.tw = word_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.base  <= BASE_LO_A;
            st_q.fast  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tune_valid = st_q.tv;
    assign tune_word  = st_q.tw;

    // R6
    valid_needs_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tune_valid |-> $past(take));

    // R3
    fast_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q.fast) |=> !tune_valid);

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.phase == 0 && st_q.integ == 0 && st_q.y == 0
                     && st_q.fast && !tune_valid));

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(tune_word));
endmodule

// File: tb/clkpi_loop_filter_bench.sv
module clkpi_loop_filter_bench;
    localparam int EXP_L = 29184;
    localparam int EXP_H = 49152;
    localparam int NV    = 8;

    // error per step, strobe expected, word expected (R3 R4 R5 R7)
    localparam int VD [NV] = '{3, 2, 0, -1, 0, 1, -2, 0};
    localparam int VV [NV] = '{0, 1, 1, 1, 1, 1, 1, 1};
    localparam int VW [NV] = '{0, 496393, 496386, 496383, 496381, 496375, 496378, 496380};
    localparam int VP [NV] = '{16'h1000, 16'hF000, 16'hB800, 16'hFFFF,
                               16'h0000, 16'hE000, 16'h9000, 16'h7FFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        rate_sel = 1'b0;
    logic        meas_valid = 1'b0;
    logic [15:0] snap_now = '0;
    logic [15:0] snap_prev = '0;
    logic        tune_valid;
    logic [19:0] tune_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkpi_loop_filter u_clkpi_loop_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .rate_sel   (rate_sel),
        .meas_valid (meas_valid),
        .snap_now   (snap_now),
        .snap_prev  (snap_prev),
        .tune_valid (tune_valid),
        .tune_word  (tune_word)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic measure(input int d, input int expc, input int prev);
        @(negedge clk);
        snap_prev  = 16'(prev);
        snap_now   = 16'(prev + expc + d);
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic do_restart(input logic r);
        @(negedge clk);
        restart  = 1'b1;
        rate_sel = r;
        @(negedge clk);
        restart  = 1'b0;
        rate_sel = 1'b0;
    endtask

    initial begin
        logic [19:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", tune_valid, 0);
        chk("R1 reset word", tune_word, 0);

        // vector table: fast lock then tracking, snapshots straddling the wrap
        for (int i = 0; i < NV; i++) begin
            measure(VD[i], EXP_L, VP[i]);
            chk($sformatf("R2 R3 R6 step %0d valid", i), tune_valid, VV[i]);
            if (VV[i] != 0)
                chk($sformatf("R4 R5 R7 step %0d word", i), tune_word, VW[i]);
            @(negedge clk);
            chk($sformatf("R6 step %0d strobe width", i), tune_valid, 0);
        end

        // idle: no strobe, word held
        held = tune_word;
        repeat (3) @(negedge clk);
        chk("R6 idle valid", tune_valid, 0);
        chk("R6 idle word held", tune_word, held);

        // restart clears state; zero error keeps y at 0, so no strobe
        do_restart(1'b0);
        measure(0, EXP_L, 16'h2222);
        chk("R3 fast lock no strobe", tune_valid, 0);
        measure(0, EXP_L, 16'h3333);
        chk("R6 unchanged y no strobe", tune_valid, 0);
        chk("R6 unchanged y word held", tune_word, held);
        measure(2, EXP_L, 16'hFFF0);
        chk("R8 R9 cleared state word", tune_word, 498274);

        // restart and measurement together: measurement dropped
        @(negedge clk);
        restart = 1'b1; meas_valid = 1'b1;
        snap_prev = 16'h0100; snap_now = 16'(16'h0100 + EXP_L + 5);
        @(negedge clk);
        restart = 1'b0; meas_valid = 1'b0;
        chk("R8 meas ignored on restart", tune_valid, 0);
        measure(0, EXP_L, 16'h0200);
        chk("R8 fast lock re-armed", tune_valid, 0);
        measure(2, EXP_L, 16'h0300);
        chk("R8 priority word", tune_word, 498274);

        // high rate: expected count and base value latched at restart
        do_restart(1'b1);
        measure(0, EXP_H, 16'hC000);
        chk("R2 high rate fast lock", tune_valid, 0);
        measure(1, EXP_H, 16'hD000);
        chk("R2 R9 high rate valid", tune_valid, 1);
        chk("R2 R9 high rate word", tune_word, 478146);

        // clamp high
        do_restart(1'b0);
        measure(-32768, EXP_L, 16'h4000);
        measure(1, EXP_L, 16'h5000);
        chk("R7 clamp high valid", tune_valid, 1);
        chk("R7 clamp high word", tune_word, 20'hFFFFF);

        // clamp low
        do_restart(1'b0);
        measure(32767, EXP_L, 16'h6000);
        measure(1, EXP_L, 16'h7000);
        chk("R7 clamp low valid", tune_valid, 1);
        chk("R7 clamp low word", tune_word, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule